// File: doc/BRIEF.md
# Key-Gated Flash Command Register Front End

This block is the software-visible register layer of an embedded flash controller. A 32-bit register bus reaches six registers: a mode register, a write-only command register, a status register, a result register, a constant version register and a write-protection register. A write to the command register starts a flash operation only when its top byte holds the command key. The operation code and its 16-bit argument then go to a back end as a one-cycle start pulse.

The back end runs the operation. It signals completion with a done pulse and a 32-bit result. It also reports lock violations, programming failures and ECC events on four separate lines. Each status flag has its own clearing rule:
- some clear when the status register is read;
- one clears on a keyed command write;
- one clears only when a new programming operation starts.

A second, 24-bit key guards the write-protection register. While protection is on, the mode register cannot be changed.

Top module: `flash_cmd_regs`

## Requirements
- R1: After reset, status reads 0x00000001 (ready only), mode and protection read 0, `irq_o` and `be_start_o` are low.
- R2: A command write (offset 0x04) with key 0x5A in bits 31:24 and a defined code while idle raises `be_start_o` for exactly one cycle, starting the cycle after the write. `be_code_o` carries bits 7:0 and `be_arg_o` carries bits 23:8. Status bit 0 (ready) stays low from that edge until `be_done_i`.
- R3: A command write whose bits 31:24 are not 0x5A has no effect at all: no start pulse, and no status bit changes.
- R4: A keyed command write with an undefined code (0x06, or any value above 0x15) sets status bit 1 (command error) and starts nothing.
- R5: A keyed command write while an operation is in progress sets status bit 1 and starts nothing.
- R6: Status bit 1 clears on a read of the status register (offset 0x08) or on a keyed command write that does not itself fail.
- R7: Status bit 2 (lock error, set by `be_lock_err_i`) and bits 19:16 (set by `ecc_evt_i[3:0]`) clear on a status read. The read returns the value before clearing. An event in the same cycle as the read survives it.
- R8: Status bit 3 (failure, set by `be_fail_i`) is not cleared by reads. It clears only when a programming command starts (codes 0x01-0x05, 0x07, 0x11, 0x12, 0x13). Other commands leave it set.
- R9: The result register (offset 0x0C) captures `be_result_i` on each cycle where `be_done_i` is high.
- R10: The mode register (offset 0x00) stores only bit 0 (ready interrupt enable), bits 11:8 (wait states), bit 16 and bit 26. All other bits read 0.
- R11: A write to offset 0xE4 takes effect only when bits 31:8 equal 0x454643. Bit 0 then sets protection. A read returns only the protection bit.
- R12: While protection is on, writes to the mode register are ignored.
- R13: `irq_o` is high exactly when mode bit 0 is set and ready is high.
- R14: Offset 0x14 reads the version constant: `VERSION_ID` in bits 11:0 and `FIX_NUM` in bits 18:16. Undefined offsets and the command register read 0. Read data appears on `rdata_o` the cycle after `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Ready interrupt |
| be_start_o | output | 1 | One-cycle operation start to the back end |
| be_code_o | output | 8 | Operation code |
| be_arg_o | output | 16 | Operation argument |
| be_done_i | input | 1 | Operation complete pulse |
| be_result_i | input | 32 | Operation result, valid with done |
| be_lock_err_i | input | 1 | Lock violation event |
| be_fail_i | input | 1 | Programming failure event |
| ecc_evt_i | input | 4 | ECC events: single low, multiple low, single high, multiple high |

## Verification
The assertions assume that the back end sends `be_done_i` only while an operation is outstanding, and at most once per start. They also assume that `rd_i` and `wr_i` are never high in the same cycle. The stimulus keeps to this: the bench acts as the back end and pulses done one cycle at a time, only after it has seen a start. Every bus access drives a single strobe for one cycle. Event inputs are pulsed in isolation, except for the one case where a lock event deliberately coincides with a status read.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_CMD    = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h08;
  localparam logic [7:0] OFS_RESULT = 8'h0C;
  localparam logic [7:0] OFS_VER    = 8'h14;
  localparam logic [7:0] OFS_PROT   = 8'hE4;

  localparam logic [7:0]  CMD_KEY  = 8'h5A;
  localparam logic [23:0] PROT_KEY = 24'h454643;
  localparam logic [31:0] MODE_MASK = 32'h0401_0F01;
  localparam logic [7:0]  CODE_MAX = 8'h15;
  localparam logic [7:0]  CODE_HOLE = 8'h06;

  typedef struct packed {
    logic [7:0]  key;
    logic [15:0] arg;
    logic [7:0]  code;
  } cmd_word_t;

  function automatic logic code_defined(input logic [7:0] c);
    return (c <= CODE_MAX) && (c != CODE_HOLE);
  endfunction

  function automatic logic code_programs(input logic [7:0] c);
    return (c >= 8'h01 && c <= 8'h05) || c == 8'h07 ||
           (c >= 8'h11 && c <= 8'h13);
  endfunction
endpackage

// File: rtl/flash_cmd_issue.sv
module flash_cmd_issue
  import flash_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [31:0] cmd_word_i,
  input  logic        busy_i,
  output logic        keyed_o,
  output logic        accept_o,
  output logic        reject_o,
  output logic        prog_start_o,
  output logic        start_o,
  output logic [7:0]  code_o,
  output logic [15:0] arg_o
);
  cmd_word_t cw;
  assign cw = cmd_word_i;

  assign keyed_o      = cmd_wr_i && (cw.key == CMD_KEY);
  assign reject_o     = keyed_o && (busy_i || !code_defined(cw.code));
  assign accept_o     = keyed_o && !reject_o;
  assign prog_start_o = accept_o && code_programs(cw.code);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      code_o  <= '0;
      arg_o   <= '0;
    end else begin
      start_o <= accept_o;
      if (accept_o) begin
        code_o <= cw.code;
        arg_o  <= cw.arg;
      end
    end
  end

  AST_START_KEYED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(cmd_wr_i) && $past(cmd_word_i[31:24]) == CMD_KEY)); // R2
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && busy_i) |=> !start_o); // R5
endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags #(
  parameter int ECC_N = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             reject_i,
  input  logic             keyed_i,
  input  logic             prog_start_i,
  input  logic             stat_rd_i,
  input  logic             done_i,
  input  logic             lock_set_i,
  input  logic             fail_set_i,
  input  logic [ECC_N-1:0] ecc_set_i,
  output logic             busy_o,
  output logic             cmd_err_o,
  output logic             lock_err_o,
  output logic             fail_o,
  output logic [ECC_N-1:0] ecc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cmd_err_o  <= 1'b0;
      lock_err_o <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      if (accept_i)    busy_o <= 1'b1;
      else if (done_i) busy_o <= 1'b0;

      if (reject_i)                    cmd_err_o <= 1'b1;
      else if (keyed_i || stat_rd_i)   cmd_err_o <= 1'b0;

      if (lock_set_i)     lock_err_o <= 1'b1;
      else if (stat_rd_i) lock_err_o <= 1'b0;

      if (fail_set_i)        fail_o <= 1'b1;
      else if (prog_start_i) fail_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < ECC_N; g++) begin : g_ecc
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flag_q <= 1'b0;
      else if (ecc_set_i[g]) flag_q <= 1'b1;
      else if (stat_rd_i)    flag_q <= 1'b0;
    end
    assign ecc_o[g] = flag_q;
  end

  AST_LOCK_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !lock_set_i) |=> !lock_err_o); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !prog_start_i) |=> fail_o); // R8
  AST_ERR_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !reject_i) |=> !cmd_err_o); // R6
endmodule

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
  import flash_cmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_wr_i,
  input  logic [31:0] mode_wdata_i,
  input  logic        prot_wr_i,
  input  logic [23:0] prot_key_i,
  input  logic        prot_en_i,
  output logic [31:0] mode_o,
  output logic        prot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      prot_o <= 1'b0;
    end else begin
      if (mode_wr_i && !prot_o) mode_o <= mode_wdata_i & MODE_MASK;
      if (prot_wr_i && prot_key_i == PROT_KEY) prot_o <= prot_en_i;
    end
  end

  AST_WP_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_i && prot_o) |=> $stable(mode_o)); // R12
  AST_PROT_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_wr_i && prot_key_i != PROT_KEY) |=> $stable(prot_o)); // R11
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          ECC_N      = 4,
  parameter logic [11:0] VERSION_ID = 12'h1A3,
  parameter logic [2:0]  FIX_NUM    = 3'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              be_start_o,
  output logic [7:0]        be_code_o,
  output logic [15:0]       be_arg_o,
  input  logic              be_done_i,
  input  logic [31:0]       be_result_i,
  input  logic              be_lock_err_i,
  input  logic              be_fail_i,
  input  logic [ECC_N-1:0]  ecc_evt_i
);
  localparam int ECC_LSB = 16;
  localparam logic [31:0] VER_WORD = {13'b0, FIX_NUM, 4'b0, VERSION_ID};

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic cmd_wr, mode_wr, prot_wr, stat_rd;
  assign cmd_wr  = wr_i && hit(addr_i, OFS_CMD);
  assign mode_wr = wr_i && hit(addr_i, OFS_MODE);
  assign prot_wr = wr_i && hit(addr_i, OFS_PROT);
  assign stat_rd = rd_i && hit(addr_i, OFS_STAT);

  logic keyed, accept, reject, prog_start, busy;
  logic cmd_err, lock_err, fail;
  logic [ECC_N-1:0] ecc;
  logic [31:0] mode_q, result_q, status_w;
  logic prot_q;

  flash_cmd_issue u_issue (
    .clk_i, .rst_ni,
    .cmd_wr_i     (cmd_wr),
    .cmd_word_i   (wdata_i),
    .busy_i       (busy),
    .keyed_o      (keyed),
    .accept_o     (accept),
    .reject_o     (reject),
    .prog_start_o (prog_start),
    .start_o      (be_start_o),
    .code_o       (be_code_o),
    .arg_o        (be_arg_o)
  );

  flash_status_flags #(.ECC_N(ECC_N)) u_flags (
    .clk_i, .rst_ni,
    .accept_i     (accept),
    .reject_i     (reject),
    .keyed_i      (keyed),
    .prog_start_i (prog_start),
    .stat_rd_i    (stat_rd),
    .done_i       (be_done_i),
    .lock_set_i   (be_lock_err_i),
    .fail_set_i   (be_fail_i),
    .ecc_set_i    (ecc_evt_i),
    .busy_o       (busy),
    .cmd_err_o    (cmd_err),
    .lock_err_o   (lock_err),
    .fail_o       (fail),
    .ecc_o        (ecc)
  );

  flash_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .mode_wr_i    (mode_wr),
    .mode_wdata_i (wdata_i),
    .prot_wr_i    (prot_wr),
    .prot_key_i   (wdata_i[31:8]),
    .prot_en_i    (wdata_i[0]),
    .mode_o       (mode_q),
    .prot_o       (prot_q)
  );

  always_comb begin
    status_w = '0;
    status_w[0] = !busy;
    status_w[1] = cmd_err;
    status_w[2] = lock_err;
    status_w[3] = fail;
    status_w[ECC_LSB +: ECC_N] = ecc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        result_q <= '0;
    else if (be_done_i) result_q <= be_result_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      if      (hit(addr_i, OFS_MODE))   rdata_o <= mode_q;
      else if (hit(addr_i, OFS_STAT))   rdata_o <= status_w;
      else if (hit(addr_i, OFS_RESULT)) rdata_o <= result_q;
      else if (hit(addr_i, OFS_VER))    rdata_o <= VER_WORD;
      else if (hit(addr_i, OFS_PROT))   rdata_o <= {31'b0, prot_q};
      else                              rdata_o <= '0;
    end
  end

  assign irq_o = mode_q[0] && !busy;

  AST_NOT_READY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_start_o |-> !status_w[0]); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_start_o |=> !be_start_o); // R2
  AST_IRQ_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_w[0]); // R13
endmodule

// File: tb/flash_cmd_regs_tb.sv
module flash_cmd_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_STAT = 8'h08,
                         A_RES = 8'h0C, A_VER = 8'h14, A_PROT = 8'hE4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, be_start_o;
  logic [7:0]  be_code_o;
  logic [15:0] be_arg_o;
  logic        be_done_i = 1'b0, be_lock_err_i = 1'b0, be_fail_i = 1'b0;
  logic [31:0] be_result_i = '0;
  logic [3:0]  ecc_evt_i = '0;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_cmd_regs u_dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) rd_seen <= rd_i;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata_o, e);
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic done_pulse(input logic [31:0] r);
    @(negedge clk_i);
    be_done_i = 1'b1; be_result_i = r;
    @(negedge clk_i);
    be_done_i = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] k, input logic [15:0] a, input logic [7:0] c);
    return {k, a, c};
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 start", {31'b0, be_start_o}, 0);
    reg_rd(A_STAT, 32'h1, "R1 status");
    reg_rd(A_MODE, 32'h0, "R1 mode");
    reg_rd(A_PROT, 32'h0, "R1 prot");
    reg_rd(A_VER, 32'h0002_01A3, "R14 version");
    reg_rd(8'h10, 32'h0, "R14 undefined offset");
    reg_rd(A_CMD, 32'h0, "R14 command reads zero");

    // programming start
    reg_wr(A_CMD, cmd(8'h5A, 16'h1234, 8'h01));
    check("R2 start", {31'b0, be_start_o}, 1);
    check("R2 code", {24'b0, be_code_o}, 32'h01);
    check("R2 arg", {16'b0, be_arg_o}, 32'h1234);
    @(negedge clk_i);
    check("R2 pulse width", {31'b0, be_start_o}, 0);
    reg_rd(A_STAT, 32'h0, "R2 busy");

    // command while busy
    reg_wr(A_CMD, cmd(8'h5A, 16'h0, 8'h0B));
    check("R5 no start", {31'b0, be_start_o}, 0);
    reg_rd(A_STAT, 32'h2, "R5 busy error");
    reg_rd(A_STAT, 32'h0, "R6 read clears error");

    done_pulse(32'hCAFE_F00D);
    reg_rd(A_STAT, 32'h1, "R2 ready after done");
    reg_rd(A_RES, 32'hCAFE_F00D, "R9 result");

    // undefined codes and wrong key
    reg_wr(A_CMD, cmd(8'h5A, 16'h0, 8'h06));
    check("R4 no start 0x06", {31'b0, be_start_o}, 0);
    reg_rd(A_STAT, 32'h3, "R4 error 0x06");
    reg_wr(A_CMD, cmd(8'hA5, 16'h0, 8'h06));
    reg_rd(A_STAT, 32'h1, "R6 cleared then wrong key no effect");
    reg_wr(A_CMD, cmd(8'h5A, 16'h0, 8'h16));
    check("R4 no start 0x16", {31'b0, be_start_o}, 0);
    reg_wr(A_CMD, cmd(8'h00, 16'h0, 8'h00));
    check("R3 wrong key no start", {31'b0, be_start_o}, 0);
    reg_wr(A_CMD, cmd(8'h5A, 16'h0, 8'h00));
    check("R6 keyed start", {31'b0, be_start_o}, 1);
    reg_rd(A_STAT, 32'h0, "R6 keyed write clears error");
    done_pulse(32'h1);

    reg_wr(A_CMD, cmd(8'h5A, 16'h0, 8'h06));
    reg_wr(A_CMD, cmd(8'h11, 16'h0, 8'h01));
    check("R3 wrong key valid code", {31'b0, be_start_o}, 0);
    reg_rd(A_STAT, 32'h3, "R3 error kept by wrong key");

    // failure flag
    @(negedge clk_i); be_fail_i = 1'b1;
    @(negedge clk_i); be_fail_i = 1'b0;
    reg_rd(A_STAT, 32'h9, "R8 fail set");
    reg_rd(A_STAT, 32'h9, "R8 fail survives read");
    reg_wr(A_CMD, cmd(8'h5A, 16'h0, 8'h0A));
    check("R8 non-prog start", {31'b0, be_start_o}, 1);
    done_pulse(32'h0);
    reg_rd(A_STAT, 32'h9, "R8 non-prog keeps fail");
    reg_wr(A_CMD, cmd(8'h5A, 16'h0055, 8'h12));
    check("R8 prog code", {24'b0, be_code_o}, 32'h12);
    reg_rd(A_STAT, 32'h0, "R8 prog start clears fail");
    done_pulse(32'h0);

    // lock / ecc
    @(negedge clk_i); be_lock_err_i = 1'b1; ecc_evt_i = 4'b1010;
    @(negedge clk_i); be_lock_err_i = 1'b0; ecc_evt_i = 4'b0000;
    reg_rd(A_STAT, 32'h000A_0005, "R7 events set");
    reg_rd(A_STAT, 32'h1, "R7 cleared on read");
    @(negedge clk_i);
    addr_i = A_STAT; rd_i = 1'b1; be_lock_err_i = 1'b1;
    exp_q.push_back(32'h1); tag_q.push_back("R7 read returns pre-set value");
    @(negedge clk_i);
    rd_i = 1'b0; be_lock_err_i = 1'b0;
    reg_rd(A_STAT, 32'h5, "R7 event wins over read");
    reg_rd(A_STAT, 32'h1, "R7 cleared after");

    // mode and irq
    reg_wr(A_MODE, 32'hFFFF_FFFF);
    reg_rd(A_MODE, 32'h0401_0F01, "R10 mode mask");
    check("R13 irq when ready", {31'b0, irq_o}, 1);
    reg_wr(A_CMD, cmd(8'h5A, 16'h0, 8'h0D));
    check("R13 irq low busy", {31'b0, irq_o}, 0);
    done_pulse(32'h0);
    check("R13 irq back", {31'b0, irq_o}, 1);

    // protection
    reg_wr(A_PROT, 32'h1234_5601);
    reg_rd(A_PROT, 32'h0, "R11 bad key ignored");
    reg_wr(A_PROT, 32'h4546_4301);
    reg_rd(A_PROT, 32'h1, "R11 enabled, key reads zero");
    reg_wr(A_MODE, 32'h0);
    reg_rd(A_MODE, 32'h0401_0F01, "R12 mode held");
    check("R12 irq kept", {31'b0, irq_o}, 1);
    reg_wr(A_PROT, 32'h4546_4300);
    reg_rd(A_PROT, 32'h0, "R11 disabled");
    reg_wr(A_MODE, 32'h0000_0300);
    reg_rd(A_MODE, 32'h0000_0300, "R12 mode writable again");
    check("R13 irq off", {31'b0, irq_o}, 0);

    repeat (2) @(negedge clk_i);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule